// File: doc/BRIEF.md
# Modular Exponentiation Host Register Interface

This block is the host-facing register front end of a parameterised RSA modular-exponentiation accelerator. A host reaches it over a 32-bit, word-addressed bus with chip-select, write-enable, address, write-data and read-data signals. The most significant address bit splits the space into two halves. The lower half holds control and status registers. The upper half is an operand window onto four equal banks of external operand memory. Each bank holds 2^ADDR_W words, which is 4 * 2^ADDR_W bytes.

The block stores three values: the CRT mode flag, the modulus length and the exponent length. It rejects length writes that fall outside their legal range and records each rejection in a sticky error flag. It also reports two read-only capability values, the operand buffer length and the systolic array length. A command register produces one-cycle start pulses for precomputation and for exponentiation. The engine answers each start with a done pulse, and the block uses these pulses to maintain the `ready` and `valid` status bits. The arithmetic engine and the operand memories sit outside this block.

Top module: `mxp_ctrl_regs`

## Requirements
- R1: After reset, all of the following hold:
  - status reads 0.
  - mode reads 0.
  - modulus length reads 64.
  - exponent length reads 2.
  - the error register reads 0.
  - neither start pulse is high.
- R2: Two registers are read-only capability values:
  - index 5 returns the buffer length 32*2^ADDR_W.
  - index 6 returns the array length 32*2^ARRAY_POW.
  - writes to either index change nothing.
- R3: The mode register (index 2) keeps only bit 1, the CRT flag. On readback, bits 0 and 31:2 are zero. The `crtMode` output follows bit 1.
- R4: The modulus length (index 3) accepts a value only if it meets all three conditions:
  - it is a multiple of 32.
  - it is at least 64.
  - it is no more than the current limit.

  Any other value leaves the register unchanged and sets bit 0 of the error register (index 7). Writing 1 to that bit clears it.
- R5: While CRT mode is set, the modulus-length limit is 16*2^ADDR_W. Otherwise the limit is 32*2^ADDR_W.
- R6: The exponent length (index 4) accepts any value from 2 to 32*2^ADDR_W. Any other value is rejected: the register keeps its old value and the error bit is set.
- R7: Precomputation start:
  - Trigger: writing bit 0 = 1 to the command register (index 0) while the engine is idle.
  - `precompStart` is high for exactly the one cycle after the write edge, and status bit 0 (`ready`) clears.
  - `ready` sets on `precompDone`.
- R8: Exponentiation start:
  - Trigger: writing bit 1 = 1 to the command register while the engine is idle and `ready` = 1.
  - `expStart` is high for one cycle, and status bit 1 (`valid`) clears.
  - `valid` sets on `expDone`.
- R9: The following commands are ignored:
  - any start command while the engine is busy.
  - an exponentiation start while `ready` = 0.

  When bits 0 and 1 are written together, only precomputation starts.
- R10: Operand window (address MSB = 1):
  - Forwarding: `opEn`, `opWe`, `opBank` = addr[ADDR_W+1:ADDR_W], `opWord` = addr[ADDR_W-1:0] and the write data go to the memory.
  - Reads: `busRdata` returns `opRdata`. The memory is assumed to have one-cycle synchronous read.
- R11: Register reads use index = addr[2:0]; the address bits between bit 2 and the MSB are ignored. `busRdata` is valid in the cycle after the read request and holds until the next read. It shows the value from before any update that lands on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busCs | input | 1 | Bus access strobe |
| busWe | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W+3 | Word address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, one cycle after request |
| opEn | output | 1 | Operand memory access enable |
| opWe | output | 1 | Operand memory write enable |
| opBank | output | 2 | Operand bank select |
| opWord | output | ADDR_W | Word within bank |
| opWdata | output | 32 | Operand write data |
| opRdata | input | 32 | Operand memory read data |
| crtMode | output | 1 | CRT mode flag |
| modBits | output | ADDR_W+6 | Modulus length in bits |
| expBits | output | ADDR_W+6 | Exponent length in bits |
| precompStart | output | 1 | One-cycle precomputation start |
| expStart | output | 1 | One-cycle exponentiation start |
| precompDone | input | 1 | Engine precomputation done pulse |
| expDone | input | 1 | Engine exponentiation done pulse |

## Verification
Two collisions are provoked by driving both events in the same cycle.

In the first, an engine done pulse lands on the same edge as a host command write. The bench raises `precompDone` in the same cycle as a write of the exponentiation-start bit. It then judges that `expStart` stays low, because the engine was still busy at that edge, and that `ready` is 1 afterwards.

In the second, `expDone` lands on the same edge as a status read. The returned word must still show `valid` = 0, and only a following read may show it set.

// File: rtl/mxp_pkg.sv
package mxp_pkg;

  localparam int REG_CMD    = 0;
  localparam int REG_STAT   = 1;
  localparam int REG_MODE   = 2;
  localparam int REG_MODLEN = 3;
  localparam int REG_EXPLEN = 4;
  localparam int REG_BUFLEN = 5;
  localparam int REG_ARRLEN = 6;
  localparam int REG_ERR    = 7;

  typedef struct packed {
    logic wrMode;
    logic wrModLen;
    logic wrExpLen;
    logic clrErr;
    logic rdCtl;
    logic rdOp;
  } regStb_t;

  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_PRE  = 2'd1,
    ENG_EXP  = 2'd2
  } engState_t;

endpackage

// File: rtl/mxp_reg_ctl.sv
module mxp_reg_ctl
  import mxp_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busCs,
  input  logic                busWe,
  input  logic [ADDR_W+2:0]   busAddr,
  input  logic [1:0]          cmdBits,
  input  logic                precompDone,
  input  logic                expDone,
  output regStb_t             stb,
  output logic [2:0]          regIdx,
  output logic                ready,
  output logic                valid,
  output logic                busy,
  output logic                precompStart,
  output logic                expStart,
  output logic                opEn,
  output logic                opWe,
  output logic [1:0]          opBank,
  output logic [ADDR_W-1:0]   opWord
);

  localparam int AW = ADDR_W + 3;

  logic      isOp;
  logic      wrReg;
  logic      cmdWr;
  engState_t state;

  // Address decode
  assign isOp   = busAddr[AW-1];
  assign regIdx = busAddr[2:0];
  assign wrReg  = busCs && busWe && !isOp;
  assign cmdWr  = wrReg && (regIdx == 3'(REG_CMD));

  always_comb begin
    stb          = '0;
    stb.wrMode   = wrReg && (regIdx == 3'(REG_MODE));
    stb.wrModLen = wrReg && (regIdx == 3'(REG_MODLEN));
    stb.wrExpLen = wrReg && (regIdx == 3'(REG_EXPLEN));
    stb.clrErr   = wrReg && (regIdx == 3'(REG_ERR)) && cmdBits[0];
    stb.rdCtl    = busCs && !busWe && !isOp;
    stb.rdOp     = busCs && !busWe && isOp;
  end

  // Operand window forwarding
  assign opEn   = busCs && isOp;
  assign opWe   = busCs && busWe && isOp;
  assign opBank = busAddr[ADDR_W+1:ADDR_W];
  assign opWord = busAddr[ADDR_W-1:0];

  // Engine lifecycle: precompute sets ready, exponentiate sets valid
  always_ff @(posedge clk) begin
    if (!rstN) begin
      state        <= ENG_IDLE;
      ready        <= 1'b0;
      valid        <= 1'b0;
      precompStart <= 1'b0;
      expStart     <= 1'b0;
    end else begin
      precompStart <= 1'b0;
      expStart     <= 1'b0;
      unique case (state)
        ENG_IDLE: begin
          if (cmdWr && cmdBits[0]) begin
            state        <= ENG_PRE;
            ready        <= 1'b0;
            precompStart <= 1'b1;
          end else if (cmdWr && cmdBits[1] && ready) begin
            state    <= ENG_EXP;
            valid    <= 1'b0;
            expStart <= 1'b1;
          end
        end
        ENG_PRE: begin
          if (precompDone) begin
            ready <= 1'b1;
            state <= ENG_IDLE;
          end
        end
        ENG_EXP: begin
          if (expDone) begin
            valid <= 1'b1;
            state <= ENG_IDLE;
          end
        end
        default: state <= ENG_IDLE;
      endcase
    end
  end

  assign busy = (state != ENG_IDLE);

endmodule

// File: rtl/mxp_reg_dp.sv
module mxp_reg_dp
  import mxp_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int ARRAY_POW = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  regStb_t             stb,
  input  logic [2:0]          regIdx,
  input  logic [31:0]         wdata,
  input  logic                ready,
  input  logic                valid,
  input  logic [31:0]         opRdata,
  output logic [31:0]         rdata,
  output logic                crtMode,
  output logic [ADDR_W+5:0]   modBits,
  output logic [ADDR_W+5:0]   expBits
);

  localparam int LW       = ADDR_W + 6;
  localparam int BUF_BITS = 32 * (2 ** ADDR_W);
  localparam int ARR_BITS = 32 * (2 ** ARRAY_POW);
  localparam int MOD_MIN  = 64;
  localparam int EXP_MIN  = 2;

  logic [31:0] modLimit;
  logic        modOk;
  logic        expOk;
  logic        errFlag;
  logic [31:0] rdMux;
  logic [31:0] rdHold;
  logic        rdFromOp;

  // Legality checks, limit halves in CRT mode
  assign modLimit = crtMode ? 32'(BUF_BITS / 2) : 32'(BUF_BITS);
  assign modOk    = (wdata[4:0] == 5'd0) && (wdata >= 32'(MOD_MIN)) && (wdata <= modLimit);
  assign expOk    = (wdata >= 32'(EXP_MIN)) && (wdata <= 32'(BUF_BITS));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      crtMode <= 1'b0;
      modBits <= LW'(MOD_MIN);
      expBits <= LW'(EXP_MIN);
      errFlag <= 1'b0;
    end else begin
      if (stb.wrMode) crtMode <= wdata[1];
      if (stb.wrModLen) begin
        if (modOk) modBits <= wdata[LW-1:0];
        else       errFlag <= 1'b1;
      end
      if (stb.wrExpLen) begin
        if (expOk) expBits <= wdata[LW-1:0];
        else       errFlag <= 1'b1;
      end
      if (stb.clrErr) errFlag <= 1'b0;
    end
  end

  always_comb begin
    unique case (regIdx)
      3'(REG_STAT):   rdMux = {30'd0, valid, ready};
      3'(REG_MODE):   rdMux = {30'd0, crtMode, 1'b0};
      3'(REG_MODLEN): rdMux = 32'(modBits);
      3'(REG_EXPLEN): rdMux = 32'(expBits);
      3'(REG_BUFLEN): rdMux = 32'(BUF_BITS);
      3'(REG_ARRLEN): rdMux = 32'(ARR_BITS);
      3'(REG_ERR):    rdMux = {31'd0, errFlag};
      default:        rdMux = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdHold   <= 32'd0;
      rdFromOp <= 1'b0;
    end else begin
      if (stb.rdCtl) rdHold <= rdMux;
      if (stb.rdCtl || stb.rdOp) rdFromOp <= stb.rdOp;
    end
  end

  assign rdata = rdFromOp ? opRdata : rdHold;

endmodule

// File: rtl/mxp_ctrl_regs.sv
module mxp_ctrl_regs
  import mxp_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int ARRAY_POW = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busCs,
  input  logic                busWe,
  input  logic [ADDR_W+2:0]   busAddr,
  input  logic [31:0]         busWdata,
  output logic [31:0]         busRdata,
  output logic                opEn,
  output logic                opWe,
  output logic [1:0]          opBank,
  output logic [ADDR_W-1:0]   opWord,
  output logic [31:0]         opWdata,
  input  logic [31:0]         opRdata,
  output logic                crtMode,
  output logic [ADDR_W+5:0]   modBits,
  output logic [ADDR_W+5:0]   expBits,
  output logic                precompStart,
  output logic                expStart,
  input  logic                precompDone,
  input  logic                expDone
);

  regStb_t    stb;
  logic [2:0] regIdx;
  logic       statusReady;
  logic       statusValid;
  logic       engBusy;

  assign opWdata = busWdata;

  mxp_reg_ctl #(.ADDR_W(ADDR_W)) u_ctl (
    .clk          (clk),
    .rstN         (rstN),
    .busCs        (busCs),
    .busWe        (busWe),
    .busAddr      (busAddr),
    .cmdBits      (busWdata[1:0]),
    .precompDone  (precompDone),
    .expDone      (expDone),
    .stb          (stb),
    .regIdx       (regIdx),
    .ready        (statusReady),
    .valid        (statusValid),
    .busy         (engBusy),
    .precompStart (precompStart),
    .expStart     (expStart),
    .opEn         (opEn),
    .opWe         (opWe),
    .opBank       (opBank),
    .opWord       (opWord)
  );

  mxp_reg_dp #(.ADDR_W(ADDR_W), .ARRAY_POW(ARRAY_POW)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .regIdx  (regIdx),
    .wdata   (busWdata),
    .ready   (statusReady),
    .valid   (statusValid),
    .opRdata (opRdata),
    .rdata   (busRdata),
    .crtMode (crtMode),
    .modBits (modBits),
    .expBits (expBits)
  );

endmodule

// File: rtl/mxp_ctrl_regs_chk.sv
module mxp_ctrl_regs_chk #(
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              precompStart,
  input logic              expStart,
  input logic              statusReady,
  input logic              statusValid,
  input logic              engBusy,
  input logic [ADDR_W+5:0] modBits,
  input logic [ADDR_W+5:0] expBits
);

  localparam int BUF_BITS = 32 * (2 ** ADDR_W);

  // R7: start pulse lasts one cycle and ready is low while it is out
  p_pre_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    precompStart |=> !precompStart);
  p_pre_clears_ready_r7: assert property (@(posedge clk) disable iff (!rstN)
    precompStart |-> !statusReady);

  // R8: exponentiation only from a ready state, and valid is low meanwhile
  p_exp_needs_ready_r8: assert property (@(posedge clk) disable iff (!rstN)
    expStart |-> (statusReady && !statusValid));

  // R9: never both starts, no start issued from a busy engine
  p_single_start_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(precompStart && expStart));
  p_busy_no_start_r9: assert property (@(posedge clk) disable iff (!rstN)
    $past(engBusy) |-> !(precompStart || expStart));

  // R4: stored modulus length is always well formed
  p_mod_legal_r4: assert property (@(posedge clk) disable iff (!rstN)
    (modBits[4:0] == 5'd0) && (32'(modBits) >= 32'd64) && (32'(modBits) <= 32'(BUF_BITS)));

  // R6: stored exponent length stays within range
  p_exp_legal_r6: assert property (@(posedge clk) disable iff (!rstN)
    (32'(expBits) >= 32'd2) && (32'(expBits) <= 32'(BUF_BITS)));

endmodule

bind mxp_ctrl_regs mxp_ctrl_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .precompStart (precompStart),
  .expStart     (expStart),
  .statusReady  (statusReady),
  .statusValid  (statusValid),
  .engBusy      (engBusy),
  .modBits      (modBits),
  .expBits      (expBits)
);

// File: tb/mxp_ctrl_regs_tb.sv
`timescale 1ns/1ps
module mxp_ctrl_regs_tb;

  localparam int ADDR_W    = 5;
  localparam int ARRAY_POW = 2;
  localparam int AW        = ADDR_W + 3;
  localparam int BUFB      = 32 * (2 ** ADDR_W);
  localparam int ARRB      = 32 * (2 ** ARRAY_POW);

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              busCs = 1'b0, busWe = 1'b0;
  logic [AW-1:0]     busAddr = '0;
  logic [31:0]       busWdata = '0;
  logic [31:0]       busRdata;
  logic              opEn, opWe;
  logic [1:0]        opBank;
  logic [ADDR_W-1:0] opWord;
  logic [31:0]       opWdata;
  logic [31:0]       opRdata;
  logic              crtMode;
  logic [ADDR_W+5:0] modBits, expBits;
  logic              precompStart, expStart;
  logic              precompDone = 1'b0, expDone = 1'b0;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  mxp_ctrl_regs #(.ADDR_W(ADDR_W), .ARRAY_POW(ARRAY_POW)) u_dut (
    .clk(clk), .rstN(rstN), .busCs(busCs), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .opEn(opEn), .opWe(opWe),
    .opBank(opBank), .opWord(opWord), .opWdata(opWdata), .opRdata(opRdata),
    .crtMode(crtMode), .modBits(modBits), .expBits(expBits),
    .precompStart(precompStart), .expStart(expStart),
    .precompDone(precompDone), .expDone(expDone)
  );

  // Operand memory stub with one-cycle synchronous read
  logic [31:0] opMem [0:4*(2**ADDR_W)-1];
  always_ff @(posedge clk) begin
    if (opEn) begin
      if (opWe) opMem[{opBank, opWord}] <= opWdata;
      else      opRdata <= opMem[{opBank, opWord}];
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    busCs = 1'b1; busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busCs = 1'b0; busWe = 1'b0;
  endtask

  task automatic busRead(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    busCs = 1'b1; busWe = 1'b0; busAddr = a;
    @(negedge clk);
    busCs = 1'b0;
    d = busRdata;
  endtask

  task automatic pulseDone(input bit isExp);
    @(negedge clk);
    if (isExp) expDone = 1'b1; else precompDone = 1'b1;
    @(negedge clk);
    expDone = 1'b0; precompDone = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 precompStart", 32'(precompStart), 0);
    check("R1 expStart", 32'(expStart), 0);
    busRead(1, v); check("R1 status", v, 0);
    busRead(2, v); check("R1 mode", v, 0);
    busRead(3, v); check("R1 modlen", v, 64);
    busRead(4, v); check("R1 explen", v, 2);
    busRead(7, v); check("R1 err", v, 0);
  endtask

  task automatic t_caps();
    logic [31:0] v;
    busRead(5, v); check("R2 buflen", v, BUFB);
    busRead(6, v); check("R2 arrlen", v, ARRB);
    busWrite(5, 32'h55); busWrite(6, 32'h77);
    busRead(5, v); check("R2 buflen after write", v, BUFB);
    busRead(6, v); check("R2 arrlen after write", v, ARRB);
  endtask

  task automatic t_mode();
    logic [31:0] v;
    busWrite(2, 32'hFFFF_FFFF);
    busRead(2, v); check("R3 mode all ones", v, 2);
    check("R3 crtMode out", 32'(crtMode), 1);
    busWrite(2, 32'hFFFF_FFFD);
    busRead(2, v); check("R3 mode bit1 clear", v, 0);
    check("R3 crtMode off", 32'(crtMode), 0);
  endtask

  task automatic t_modlen();
    logic [31:0] v;
    busWrite(3, BUFB); busRead(3, v); check("R4 max accepted", v, BUFB);
    busRead(7, v); check("R4 no err", v, 0);
    busWrite(3, BUFB + 32); busRead(3, v); check("R4 over max kept", v, BUFB);
    busRead(7, v); check("R4 err set", v, 1);
    busWrite(7, 1); busRead(7, v); check("R4 err cleared", v, 0);
    busWrite(3, 100); busRead(3, v); check("R4 non multiple kept", v, BUFB);
    busWrite(3, 32); busRead(3, v); check("R4 below min kept", v, BUFB);
    busWrite(3, 64); busRead(3, v); check("R4 min accepted", v, 64);
    check("R4 modBits out", 32'(modBits), 64);
    busWrite(7, 1);
  endtask

  task automatic t_crt();
    logic [31:0] v;
    busWrite(2, 2);
    busWrite(3, BUFB); busRead(3, v); check("R5 full rejected in crt", v, 64);
    busRead(7, v); check("R5 err in crt", v, 1);
    busWrite(7, 1);
    busWrite(3, BUFB/2); busRead(3, v); check("R5 half accepted", v, BUFB/2);
    busWrite(3, BUFB/2 + 32); busRead(3, v); check("R5 half plus rejected", v, BUFB/2);
    busWrite(2, 0); busWrite(7, 1);
    busWrite(3, BUFB); busRead(3, v); check("R5 full after crt off", v, BUFB);
  endtask

  task automatic t_exp();
    logic [31:0] v;
    busWrite(4, 1); busRead(4, v); check("R6 below min kept", v, 2);
    busRead(7, v); check("R6 err set", v, 1);
    busWrite(7, 1);
    busWrite(4, 17); busRead(4, v); check("R6 odd accepted", v, 17);
    busWrite(4, BUFB + 1); busRead(4, v); check("R6 over max kept", v, 17);
    busWrite(4, BUFB); busRead(4, v); check("R6 max accepted", v, BUFB);
    check("R6 expBits out", 32'(expBits), BUFB);
    busWrite(7, 1);
  endtask

  task automatic t_engine();
    logic [31:0] v;
    busWrite(0, 2);
    check("R9 exp without ready", 32'(expStart), 0);
    busRead(1, v); check("R9 status unchanged", v, 0);
    busWrite(0, 1);
    check("R7 precompStart pulse", 32'(precompStart), 1);
    @(negedge clk);
    check("R7 pulse one cycle", 32'(precompStart), 0);
    busWrite(0, 1);
    check("R9 precomp while busy", 32'(precompStart), 0);
    busRead(1, v); check("R7 ready low", v, 0);
    pulseDone(0);
    busRead(1, v); check("R7 ready set", v, 1);
    busWrite(0, 2);
    check("R8 expStart pulse", 32'(expStart), 1);
    busWrite(0, 2);
    check("R9 exp while busy", 32'(expStart), 0);
    busRead(1, v); check("R8 valid low", v, 1);
    pulseDone(1);
    busRead(1, v); check("R8 valid set", v, 3);
    busWrite(0, 3);
    check("R9 both bits precomp", 32'(precompStart), 1);
    check("R9 both bits no exp", 32'(expStart), 0);
    busRead(1, v); check("R9 both bits status", v, 2);
    pulseDone(0);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    busWrite(0, 1);
    @(negedge clk);
    precompDone = 1'b1; busCs = 1'b1; busWe = 1'b1; busAddr = 0; busWdata = 2;
    @(negedge clk);
    precompDone = 1'b0; busCs = 1'b0; busWe = 1'b0;
    check("R9 exp on done edge ignored", 32'(expStart), 0);
    busRead(1, v); check("R9 ready after collide", v, 3);
    busWrite(0, 2);
    check("R8 exp started", 32'(expStart), 1);
    @(negedge clk);
    expDone = 1'b1; busCs = 1'b1; busWe = 1'b0; busAddr = 1;
    @(negedge clk);
    expDone = 1'b0; busCs = 1'b0;
    check("R11 read sees pre-update status", busRdata, 1);
    busRead(1, v); check("R8 valid after done", v, 3);
  endtask

  task automatic t_operand();
    logic [31:0] v;
    logic [AW-1:0] a;
    a = {1'b1, 2'd2, 5'd5};
    @(negedge clk);
    busCs = 1'b1; busWe = 1'b1; busAddr = a; busWdata = 32'hCAFE_0123;
    #1;
    check("R10 opWe", 32'(opWe), 1);
    check("R10 opBank", 32'(opBank), 2);
    check("R10 opWord", 32'(opWord), 5);
    check("R10 opWdata", opWdata, 32'hCAFE_0123);
    @(negedge clk);
    busCs = 1'b0; busWe = 1'b0;
    busWrite({1'b1, 2'd3, 5'd31}, 32'h1234_5678);
    busRead(a, v); check("R10 read bank2", v, 32'hCAFE_0123);
    busRead({1'b1, 2'd3, 5'd31}, v); check("R10 read bank3", v, 32'h1234_5678);
    busRead(8'h0D, v); check("R11 alias index5", v, BUFB);
    busRead(8'h71, v); check("R11 alias status", v, 3);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_caps();
    t_mode();
    t_modlen();
    t_crt();
    t_exp();
    t_engine();
    t_collide();
    t_operand();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule